// File: doc/BRIEF.md
# Nested Prioritized Vectored Interrupt Controller

This block collects 41 maskable interrupt request lines and one software break request and decides which request the CPU core should service next. Each maskable source holds a pending flag, a mask bit and a two-bit priority level. Level 0 is the most urgent and level 3 the least. Among the unmasked pending sources, the lowest level number wins. Within one level, the lower source index wins. The block offers the winner to the core as a request with a 16-bit vector table address. It also tracks the level now being serviced, so that only a strictly more urgent request can interrupt a running handler.

The core accepts an offered request by pulsing an acknowledge. That pulse clears the winning flag and saves the previous in-service level on a small stack. A return pulse restores the saved level. The software break is a separate request. It is offered ahead of every maskable source, even when the core has interrupts globally disabled, and it leaves the in-service level as it is. A wake output goes high whenever any unmasked request or a break is pending, so that the core can leave halt or stop modes. A single-cycle write port sets the mask bit and priority level of one source.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, every source is masked at level 3, no flag is pending, `reqValid` and `wake` are 0, and `inService` reads 4 (meaning idle).
- R2: A high `irqIn[n]` at a clock edge sets the flag of source n. The flag stays set until that source is acknowledged. `wake` is 1 whenever an unmasked flag or a break is pending, whatever the values of `globalEn` and `inService`.
- R3: A source whose mask bit is 1 is never offered and does not raise `wake`, even if its flag is pending.
- R4: A write with `wrEn` high and `wrSrc` below 41 loads `wrMask` and `wrLevel` into that source at the clock edge. A write with `wrSrc` of 41 or more changes nothing.
- R5: Among the eligible sources, the one with the lowest level number is offered. When levels are equal, the lowest source index is offered.
- R6: The vector for maskable source n is 0x0004 + 2·n. The vector for the break is 0x007E.
- R7: A maskable source is offered only when `globalEn` is 1 and its level number is strictly below `inService`.
- R8: An acknowledge of a maskable request clears that source's flag, saves the old `inService` on the stack, and sets `inService` to the source's level on the next cycle.
- R9: A `retiIn` pulse restores the most recently saved level. When the stack is empty, `inService` becomes 4.
- R10: A pending break is offered ahead of any maskable source, whatever the values of `globalEn` and `inService`. Its acknowledge clears the break, saves the level, and leaves `inService` unchanged.
- R11: While the stack holds 4 saved levels, no request is offered. Offering resumes after a return.
- R12: `ackIn` has no effect when `reqValid` is 0, and no effect when it arrives together with `retiIn`. In the second case only the return takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 41 | Request lines, one per maskable source |
| swBrk | input | 1 | Break instruction request pulse |
| globalEn | input | 1 | Global interrupt enable from the core |
| wrEn | input | 1 | Configuration write strobe |
| wrSrc | input | 6 | Source index to configure |
| wrMask | input | 1 | Mask bit to write (1 = masked) |
| wrLevel | input | 2 | Priority level to write (0 = most urgent) |
| ackIn | input | 1 | Core accepts the offered request |
| retiIn | input | 1 | Core returns from a handler |
| reqValid | output | 1 | A request is offered to the core |
| reqVector | output | 16 | Vector table address of the offered request |
| inService | output | 3 | Level now being serviced (4 = idle) |
| wake | output | 1 | Release from halt and stop modes |

## Verification
A wrong flag, mask or level register shows up at once as a wrong `reqValid`, `reqVector` or `wake` in the cycle after the faulty update. A corrupted stack entry stays hidden until the matching return, and then appears as a wrong `inService` value and as the wrong nesting decision on the next request. For this reason the reference model is compared on every clock during a long random phase in which handlers nest several levels deep and returns follow.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W     = 2;
  localparam int NUM_LVLS  = 1 << LVL_W;
  localparam int ISV_W     = LVL_W + 1;
  localparam logic [ISV_W-1:0] ISV_IDLE = ISV_W'(NUM_LVLS);

  typedef struct packed {
    logic clrReq;
    logic clrSw;
  } nic_strobe_t;
endpackage

// File: rtl/nic_datapath.sv
module nic_datapath
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 41,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic              swBrk,
  input  logic              wrEn,
  input  logic [SRC_W-1:0]  wrSrc,
  input  logic              wrMask,
  input  logic [LVL_W-1:0]  wrLevel,
  input  nic_strobe_t       strobe,
  output logic              bestValid,
  output logic [SRC_W-1:0]  bestIdx,
  output logic [LVL_W-1:0]  bestLvl,
  output logic              swPend,
  output logic              wake
);
  logic [NUM_SRC-1:0] reqFlag;
  logic [NUM_SRC-1:0] maskBit;
  logic [LVL_W-1:0]   lvlReg [NUM_SRC];
  logic [NUM_SRC-1:0] liveReq;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      logic wrHit;
      logic clrHit;
      assign wrHit  = wrEn && (wrSrc == SRC_W'(g));
      assign clrHit = strobe.clrReq && (bestIdx == SRC_W'(g));
      assign liveReq[g] = reqFlag[g] && !maskBit[g];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          reqFlag[g] <= 1'b0;
          maskBit[g] <= 1'b1;
          lvlReg[g]  <= '1;
        end else begin
          reqFlag[g] <= (reqFlag[g] && !clrHit) || irqIn[g];
          if (wrHit) begin
            maskBit[g] <= wrMask;
            lvlReg[g]  <= wrLevel;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) swPend <= 1'b0;
    else       swPend <= (swPend && !strobe.clrSw) || swBrk;
  end

  // Lowest level wins; strict compare keeps the lower index on ties.
  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestLvl   = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (liveReq[i] && (!bestValid || lvlReg[i] < bestLvl)) begin
        bestValid = 1'b1;
        bestIdx   = SRC_W'(i);
        bestLvl   = lvlReg[i];
      end
    end
  end

  assign wake = (|liveReq) || swPend;

  a_r2_wake_covers: assert property (@(posedge clk) disable iff (!rstN)
    (bestValid || swPend) |-> wake);
  a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrReq && !irqIn[bestIdx]) |=> !reqFlag[$past(bestIdx)]);
  a_r4_write_takes: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (int'(wrSrc) < NUM_SRC)) |=> maskBit[$past(wrSrc)] == $past(wrMask));
  a_r3_masked_never_best: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && wrMask && (int'(wrSrc) < NUM_SRC)) |-> !(bestValid && bestIdx == $past(wrSrc)));
endmodule

// File: rtl/nic_control.sv
module nic_control
  import nic_pkg::*;
#(
  parameter int          SRC_W       = 6,
  parameter int          STACK_DEPTH = 4,
  parameter logic [15:0] VEC_BASE    = 16'h0004,
  parameter logic [15:0] SW_VEC      = 16'h007E
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalEn,
  input  logic             ackIn,
  input  logic             retiIn,
  input  logic             bestValid,
  input  logic [SRC_W-1:0] bestIdx,
  input  logic [LVL_W-1:0] bestLvl,
  input  logic             swPend,
  output logic             reqValid,
  output logic [15:0]      reqVector,
  output logic [ISV_W-1:0] inService,
  output nic_strobe_t      strobe
);
  localparam int PTR_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int SP_W  = $clog2(STACK_DEPTH + 1);

  logic [ISV_W-1:0] curLvl;
  logic [ISV_W-1:0] lvlStack [STACK_DEPTH];
  logic [SP_W-1:0]  sp;
  logic             stackFull;
  logic             eligible;
  logic             accept;
  logic [SP_W-1:0]  spDec;

  assign stackFull = (sp == SP_W'(STACK_DEPTH));
  assign eligible  = bestValid && globalEn && ({1'b0, bestLvl} < curLvl);
  assign reqValid  = !stackFull && (swPend || eligible);
  assign reqVector = swPend ? SW_VEC
                            : VEC_BASE + {{(15-SRC_W){1'b0}}, bestIdx, 1'b0};
  assign accept    = ackIn && reqValid && !retiIn;
  assign spDec     = sp - SP_W'(1);

  always_comb begin
    strobe        = '0;
    strobe.clrSw  = accept && swPend;
    strobe.clrReq = accept && !swPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLvl <= ISV_IDLE;
      sp     <= '0;
      for (int k = 0; k < STACK_DEPTH; k++) lvlStack[k] <= ISV_IDLE;
    end else if (retiIn) begin
      if (sp != '0) begin
        curLvl <= lvlStack[spDec[PTR_W-1:0]];
        sp     <= spDec;
      end else begin
        curLvl <= ISV_IDLE;
      end
    end else if (accept) begin
      lvlStack[sp[PTR_W-1:0]] <= curLvl;
      sp <= sp + SP_W'(1);
      if (!swPend) curLvl <= {1'b0, bestLvl};
    end
  end

  assign inService = curLvl;

  a_r8_level_rises: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrReq |=> curLvl < $past(curLvl));
  a_r10_sw_keeps_level: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrSw |=> curLvl == $past(curLvl));
  a_r11_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (sp == SP_W'(STACK_DEPTH)) |-> !reqValid);
  a_r7_enable_needed: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !swPend) |-> globalEn);
  a_r9_pop_not_deeper: assert property (@(posedge clk) disable iff (!rstN)
    (retiIn && sp != '0) |=> curLvl >= $past(curLvl));
  a_r12_no_dual: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int          NUM_SRC     = 41,
  parameter int          SRC_W       = $clog2(NUM_SRC),
  parameter int          STACK_DEPTH = 4,
  parameter logic [15:0] VEC_BASE    = 16'h0004,
  parameter logic [15:0] SW_VEC      = 16'h007E
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               swBrk,
  input  logic               globalEn,
  input  logic               wrEn,
  input  logic [SRC_W-1:0]   wrSrc,
  input  logic               wrMask,
  input  logic [1:0]         wrLevel,
  input  logic               ackIn,
  input  logic               retiIn,
  output logic               reqValid,
  output logic [15:0]        reqVector,
  output logic [2:0]         inService,
  output logic               wake
);
  nic_strobe_t      strobe;
  logic             bestValid;
  logic [SRC_W-1:0] bestIdx;
  logic [LVL_W-1:0] bestLvl;
  logic             swPend;

  nic_datapath #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .swBrk(swBrk),
    .wrEn(wrEn), .wrSrc(wrSrc), .wrMask(wrMask), .wrLevel(wrLevel),
    .strobe(strobe), .bestValid(bestValid), .bestIdx(bestIdx),
    .bestLvl(bestLvl), .swPend(swPend), .wake(wake)
  );

  nic_control #(.SRC_W(SRC_W), .STACK_DEPTH(STACK_DEPTH),
                .VEC_BASE(VEC_BASE), .SW_VEC(SW_VEC)) i_ctl (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .ackIn(ackIn),
    .retiIn(retiIn), .bestValid(bestValid), .bestIdx(bestIdx),
    .bestLvl(bestLvl), .swPend(swPend), .reqValid(reqValid),
    .reqVector(reqVector), .inService(inService), .strobe(strobe)
  );
endmodule

// File: tb/test_nested_irq_ctrl.sv
module test_nested_irq_ctrl;
  localparam int NS = 41;

  logic clk = 0;
  logic rstN = 0;
  logic [NS-1:0] irqIn = '0;
  logic swBrk = 0, globalEn = 0, wrEn = 0, wrMask = 0, ackIn = 0, retiIn = 0;
  logic [5:0] wrSrc = '0;
  logic [1:0] wrLevel = '0;
  logic reqValid, wake;
  logic [15:0] reqVector;
  logic [2:0] inService;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nested_irq_ctrl i_nested_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .swBrk(swBrk), .globalEn(globalEn),
    .wrEn(wrEn), .wrSrc(wrSrc), .wrMask(wrMask), .wrLevel(wrLevel),
    .ackIn(ackIn), .retiIn(retiIn), .reqValid(reqValid), .reqVector(reqVector),
    .inService(inService), .wake(wake)
  );

  // Reference model
  bit mFlag[NS];
  bit mMask[NS];
  int mLvl[NS];
  bit mSw;
  int mCur;
  int mStk[$];
  bit eV, eSw, eWake;
  int eVec, eIdx, eLvl;

  task automatic modelOffer();
    bit bv = 0;
    int bi = 0, bl = 3;
    eWake = mSw;
    for (int i = 0; i < NS; i++) begin
      if (mFlag[i] && !mMask[i]) begin
        eWake = 1;
        if (!bv || mLvl[i] < bl) begin bv = 1; bi = i; bl = mLvl[i]; end
      end
    end
    eIdx = bi; eLvl = bl; eV = 0; eSw = 0; eVec = 0;
    if (mStk.size() >= 4) eV = 0;
    else if (mSw) begin eV = 1; eSw = 1; eVec = 16'h007E; end
    else if (bv && globalEn && bl < mCur) begin eV = 1; eVec = 4 + 2 * bi; end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NS; i++) begin mFlag[i] = 0; mMask[i] = 1; mLvl[i] = 3; end
      mSw = 0; mCur = 4; mStk.delete();
    end else begin
      modelOffer();
      if (retiIn) begin
        if (mStk.size() > 0) mCur = mStk.pop_back();
        else mCur = 4;
      end else if (ackIn && eV) begin
        mStk.push_back(mCur);
        if (eSw) mSw = 0;
        else begin mFlag[eIdx] = 0; mCur = eLvl; end
      end
      for (int i = 0; i < NS; i++) if (irqIn[i]) mFlag[i] = 1;
      if (swBrk) mSw = 1;
      if (wrEn && wrSrc < NS) begin mMask[wrSrc] = wrMask; mLvl[wrSrc] = wrLevel; end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      modelOffer();
      check(int'(reqValid), int'(eV), "R7 model reqValid");
      if (eV) check(int'(reqVector), eVec, "R6 model reqVector");
      check(int'(wake), int'(eWake), "R2 model wake");
      check(int'(inService), mCur, "R8 model inService");
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input int src, input bit m, input int lvl);
    wrEn = 1; wrSrc = 6'(src); wrMask = m; wrLevel = 2'(lvl);
    step(); wrEn = 0;
  endtask

  task automatic pulseIrq(input int src);
    irqIn[src] = 1; step(); irqIn = '0;
  endtask

  task automatic pulseSw();
    swBrk = 1; step(); swBrk = 0;
  endtask

  task automatic ack();
    ackIn = 1; step(); ackIn = 0;
  endtask

  task automatic reti();
    retiIn = 1; step(); retiIn = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    rstN = 1;
    step();
    check(reqValid, 0, "R1 reqValid after reset");
    check(inService, 4, "R1 inService idle");
    check(wake, 0, "R1 wake after reset");

    pulseIrq(5);
    check(wake, 0, "R3 masked flag no wake");
    check(reqValid, 0, "R3 masked flag not offered");

    globalEn = 1;
    wr(5, 0, 3);
    check(reqValid, 1, "R2 held flag offered after unmask");
    check(reqVector, 16'h000E, "R6 vector for source 5");
    check(wake, 1, "R2 wake with unmasked flag");

    wr(2, 0, 3);
    wr(9, 0, 1);
    irqIn[2] = 1; irqIn[9] = 1; step(); irqIn = '0;
    check(reqVector, 16'h0016, "R5 level 1 beats level 3");

    ack();
    check(inService, 1, "R8 inService takes winner level");
    check(reqValid, 0, "R7 level 3 cannot nest over level 1");

    wr(0, 0, 0);
    pulseIrq(0);
    check(reqValid, 1, "R7 level 0 nests over level 1");
    check(reqVector, 16'h0004, "R6 vector for source 0");
    ack();
    check(inService, 0, "R8 nested level");
    reti();
    check(inService, 1, "R9 pop to level 1");
    reti();
    check(inService, 4, "R9 pop to idle");
    reti();
    check(inService, 4, "R9 empty stack stays idle");
    check(reqVector, 16'h0008, "R5 tie goes to lower index");

    globalEn = 0; #1;
    check(reqValid, 0, "R7 global disable blocks maskable");
    check(wake, 1, "R2 wake ignores global disable");
    pulseSw();
    check(reqValid, 1, "R10 break offered while disabled");
    check(reqVector, 16'h007E, "R10 break vector");
    ack();
    check(inService, 4, "R10 break keeps level");
    check(reqValid, 0, "R10 break cleared by ack");
    reti();

    wr(2, 1, 3);
    wr(5, 1, 3);
    check(wake, 0, "R3 masking pending flags drops wake");
    wr(63, 0, 0);
    pulseIrq(30);
    check(wake, 0, "R4 out-of-range write ignored");

    for (int k = 0; k < 4; k++) begin pulseSw(); ack(); end
    pulseSw();
    check(reqValid, 0, "R11 full stack blocks break");
    reti();
    check(reqValid, 1, "R11 offering resumes after pop");
    ack();
    for (int k = 0; k < 4; k++) reti();
    check(inService, 4, "R9 stack drained");

    ack();
    check(inService, 4, "R12 ack without request ignored");
    globalEn = 1;
    pulseIrq(9);
    ackIn = 1; retiIn = 1; step(); ackIn = 0; retiIn = 0;
    check(inService, 4, "R12 ack with return ignored");
    check(reqValid, 1, "R12 request still pending");
    ack();
    check(inService, 1, "R8 ack after dual cycle");
    reti();

    for (int c = 0; c < 4000; c++) begin
      irqIn    = ($urandom_range(0, 3) == 0) ? NS'(1) << $urandom_range(0, NS - 1) : '0;
      swBrk    = ($urandom_range(0, 40) == 0);
      globalEn = ($urandom_range(0, 7) != 0);
      ackIn    = ($urandom_range(0, 2) == 0);
      retiIn   = ($urandom_range(0, 5) == 0);
      wrEn     = ($urandom_range(0, 4) == 0);
      wrSrc    = 6'($urandom_range(0, 63));
      wrMask   = ($urandom_range(0, 3) == 0);
      wrLevel  = 2'($urandom_range(0, 3));
      step();
    end
    irqIn = '0; swBrk = 0; ackIn = 0; retiIn = 0; wrEn = 0;
    step(2);
    summary();
  end
endmodule